// File: doc/BRIEF.md
# Dual-Core Failover Controller

This block decides which of two redundant processor cores owns the shared peripheral path. One core is online at a time. The `sel_o` output steers an external multiplexer that connects either the core 0 bus port or the core 1 bus port to the single peripheral-side port. The block takes two inputs that can start a handover:

- a majority-voted error indication, which has already been aggregated upstream;
- a core-reset request from the online core.

When either input is accepted, the controller enters a transitional switch state. That state lasts a fixed number of cycles. The core being taken offline gets a one-cycle reset pulse at the start of the switch. The select output moves to the other core only when the switch completes.

Each core has a sticky failed flag, which the voted error sets against the core that was online. A handover is never made to a core already marked as failed. If the voted error arrives while the standby core is marked, the controller stays where it is and raises a sticky fatal-fault output. Chip-level and system-level reset requests are not handled by switching cores. Each produces a single-cycle reset pulse of the matching kind.

Top module: `dual_core_failover`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, core 0 is online. In that state `sel_o`=0, `switching_o`=0, `core_rst_o`=2'b00, `failed_o`=2'b00, `fatal_o`=0, `chip_rst_o`=0 and `sys_rst_o`=0. The reset is asynchronous.
- R2: Each switch lasts exactly `SW_CYCLES` (default 4) clock cycles with `switching_o`=1. In the following cycle `sel_o` shows the other core and `switching_o`=0.
- R3: When core 1 is online (`sel_o`=1) and core 0 is not marked failed, an error hands the path back to core 0. The switch behaves the same as a handover in the other direction.
- R4: `core_rst_req_i` sampled high while core 0 or core 1 is online starts a handover, provided the standby core is not marked failed. It does not set any failed flag.
- R5: `sel_o` keeps its previous value for every cycle in which `switching_o`=1.
- R6: In the first cycle of a switch, `core_rst_o` is one-hot on the outgoing core for exactly one cycle. Bit i of `core_rst_o` belongs to core i. In all other cycles `core_rst_o` is zero.
- R7: While `switching_o`=1, `err_i` and `core_rst_req_i` are ignored. They start no new switch, change no failed flag and cause no reset pulse.
- R8: `err_i` sampled while core i is online sets `failed_o[i]`. The flag stays set until `rst_ni` is asserted.
- R9: If the standby core is marked failed, no switch happens. In that case `err_i` raises `fatal_o`, which is sticky until reset, and `core_rst_req_i` alone has no effect.
- R10: A rising edge on `chip_rst_req_i` gives a one-cycle pulse on `chip_rst_o`. A rising edge on `sys_rst_req_i` gives a one-cycle pulse on `sys_rst_o`. Neither changes `sel_o` or `switching_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_i | input | 1 | Voted error indication for the online core |
| core_rst_req_i | input | 1 | Core reset request from the online core |
| chip_rst_req_i | input | 1 | Chip reset request |
| sys_rst_req_i | input | 1 | System reset request |
| sel_o | output | 1 | Online core and mux select: 0 selects core 0, 1 selects core 1 |
| switching_o | output | 1 | High while a handover is in progress |
| core_rst_o | output | 2 | Per-core reset pulse; bit i goes to core i |
| chip_rst_o | output | 1 | Chip reset pulse |
| sys_rst_o | output | 1 | System reset pulse |
| failed_o | output | 2 | Sticky failed flag per core; bit i belongs to core i |
| fatal_o | output | 1 | Sticky fatal fault: both cores marked failed |

## Verification
The bound checker covers the properties that hold every cycle:

- the switch length;
- `sel_o` staying put during a switch;
- the reset pulse being one-hot, single-cycle and aimed at the outgoing core;
- failed flags and `fatal_o` never clearing;
- failed flags not changing during a switch;
- no switch once the fault is fatal;
- chip and system pulses lasting one cycle.

Some behaviour depends on history and input order, so only the bench scenarios can show it:

- the direction of each handover;
- a core reset request moving the path without marking a core;
- a blocked request leaving everything untouched;
- an edge-only response to a held chip reset request;
- recovery from an asynchronous reset in the middle of a switch.

// File: rtl/fco_pkg.sv
package fco_pkg;
  localparam int unsigned NCORE = 2;

  typedef enum logic [1:0] {
    ST_ON0  = 2'd0,
    ST_ON1  = 2'd1,
    ST_SW01 = 2'd2,
    ST_SW10 = 2'd3
  } fco_state_e;

  function automatic logic is_switch(input fco_state_e s);
    return (s == ST_SW01) || (s == ST_SW10);
  endfunction

  function automatic logic owner(input fco_state_e s);
    return (s == ST_ON1) || (s == ST_SW10);
  endfunction
endpackage

// File: rtl/fco_seq.sv
module fco_seq
  import fco_pkg::*;
#(
  parameter int unsigned SW_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic blocked_i,
  output logic start_o,
  output logic act_o,
  output logic switching_o
);
  localparam int unsigned CW = (SW_CYCLES > 1) ? $clog2(SW_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SW_CYCLES - 1);

  fco_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic last;
  logic start;

  assign last = (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    start   = 1'b0;
    case (state_q)
      ST_ON0: if (trig_i && !blocked_i) begin
        state_d = ST_SW01;
        start   = 1'b1;
      end
      ST_ON1: if (trig_i && !blocked_i) begin
        state_d = ST_SW10;
        start   = 1'b1;
      end
      ST_SW01: if (last) state_d = ST_ON1;
      ST_SW10: if (last) state_d = ST_ON0;
      default: state_d = ST_ON0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ON0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start) cnt_q <= '0;
      else if (is_switch(state_q)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign start_o     = start;
  assign act_o       = owner(state_q);
  assign switching_o = is_switch(state_q);
endmodule

// File: rtl/fco_health.sv
module fco_health
  import fco_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_hit_i,
  input  logic             act_i,
  output logic [NCORE-1:0] failed_o,
  output logic             fatal_o,
  output logic             standby_failed_o
);
  logic [NCORE-1:0] failed_q;
  logic             fatal_q;

  for (genvar g = 0; g < NCORE; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) failed_q[g] <= 1'b0;
      else if (err_hit_i && (act_i == (g != 0))) failed_q[g] <= 1'b1;
    end
  end

  assign standby_failed_o = failed_q[~act_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fatal_q <= 1'b0;
    else if (err_hit_i && standby_failed_o) fatal_q <= 1'b1;
  end

  assign failed_o = failed_q;
  assign fatal_o  = fatal_q;
endmodule

// File: rtl/fco_rst_gen.sv
module fco_rst_gen
  import fco_pkg::*;
#(
  parameter int unsigned N_EXT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             act_i,
  input  logic [N_EXT-1:0] ext_req_i,
  output logic [NCORE-1:0] core_rst_o,
  output logic [N_EXT-1:0] ext_rst_o
);
  logic [NCORE-1:0] core_q;
  logic [N_EXT-1:0] req_d_q, ext_q;

  for (genvar g = 0; g < NCORE; g++) begin : g_core
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) core_q[g] <= 1'b0;
      else         core_q[g] <= start_i && (act_i == (g != 0));
    end
  end

  // rising-edge pulse per external request
  for (genvar e = 0; e < N_EXT; e++) begin : g_ext
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_d_q[e] <= 1'b0;
        ext_q[e]   <= 1'b0;
      end else begin
        req_d_q[e] <= ext_req_i[e];
        ext_q[e]   <= ext_req_i[e] && !req_d_q[e];
      end
    end
  end

  assign core_rst_o = core_q;
  assign ext_rst_o  = ext_q;
endmodule

// File: rtl/dual_core_failover.sv
module dual_core_failover
  import fco_pkg::*;
#(
  parameter int unsigned SW_CYCLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_i,
  input  logic             core_rst_req_i,
  input  logic             chip_rst_req_i,
  input  logic             sys_rst_req_i,
  output logic             sel_o,
  output logic             switching_o,
  output logic [NCORE-1:0] core_rst_o,
  output logic             chip_rst_o,
  output logic             sys_rst_o,
  output logic [NCORE-1:0] failed_o,
  output logic             fatal_o
);
  logic act, start, sw, standby_failed, err_hit, trig;
  logic [1:0] ext_rst;

  assign trig    = err_i | core_rst_req_i;
  assign err_hit = err_i & ~sw;  // errors during a switch are dropped

  fco_seq #(.SW_CYCLES(SW_CYCLES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig),
    .blocked_i  (standby_failed),
    .start_o    (start),
    .act_o      (act),
    .switching_o(sw)
  );

  fco_health u_health (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .err_hit_i       (err_hit),
    .act_i           (act),
    .failed_o        (failed_o),
    .fatal_o         (fatal_o),
    .standby_failed_o(standby_failed)
  );

  fco_rst_gen #(.N_EXT(2)) u_rst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .act_i     (act),
    .ext_req_i ({sys_rst_req_i, chip_rst_req_i}),
    .core_rst_o(core_rst_o),
    .ext_rst_o (ext_rst)
  );

  assign chip_rst_o  = ext_rst[0];
  assign sys_rst_o   = ext_rst[1];
  assign sel_o       = act;
  assign switching_o = sw;
endmodule

// File: rtl/fco_checker.sv
module fco_checker #(
  parameter int unsigned SW_CYCLES = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_o,
  input logic       switching_o,
  input logic [1:0] core_rst_o,
  input logic       chip_rst_o,
  input logic       sys_rst_o,
  input logic [1:0] failed_o,
  input logic       fatal_o
);
  localparam int unsigned RW = $clog2(SW_CYCLES + 2) + 1;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= '0;
    else if (switching_o) run_q <= run_q + 1'b1;
    else                  run_q <= '0;
  end

  a_r2_switch_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(switching_o) |-> run_q == RW'(SW_CYCLES));
  a_r2_switch_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switching_o |-> run_q < RW'(SW_CYCLES));
  a_r5_sel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (switching_o && $past(switching_o)) |-> $stable(sel_o));
  a_r6_rst_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(core_rst_o));
  a_r6_rst_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_rst_o != 2'b00) |=> core_rst_o == 2'b00);
  a_r6_rst_outgoing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(switching_o) |-> core_rst_o[sel_o]);
  a_r7_flags_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switching_o |=> failed_o == $past(failed_o));
  a_r8_failed_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (failed_o & $past(failed_o)) == $past(failed_o));
  a_r9_fatal_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> fatal_o);
  a_r9_fatal_no_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |-> !switching_o);
  a_r10_chip_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_rst_o |=> !chip_rst_o);
  a_r10_sys_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> !sys_rst_o);
endmodule

bind dual_core_failover fco_checker #(.SW_CYCLES(SW_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_o      (sel_o),
  .switching_o(switching_o),
  .core_rst_o (core_rst_o),
  .chip_rst_o (chip_rst_o),
  .sys_rst_o  (sys_rst_o),
  .failed_o   (failed_o),
  .fatal_o    (fatal_o)
);

// File: tb/dual_core_failover_tb.sv
module dual_core_failover_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NROW = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic err_i = 1'b0, core_rst_req_i = 1'b0, chip_rst_req_i = 1'b0, sys_rst_req_i = 1'b0;
  logic sel_o, switching_o, chip_rst_o, sys_rst_o, fatal_o;
  logic [1:0] core_rst_o, failed_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_core_failover #(.SW_CYCLES(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .err_i(err_i), .core_rst_req_i(core_rst_req_i),
    .chip_rst_req_i(chip_rst_req_i), .sys_rst_req_i(sys_rst_req_i),
    .sel_o(sel_o), .switching_o(switching_o), .core_rst_o(core_rst_o),
    .chip_rst_o(chip_rst_o), .sys_rst_o(sys_rst_o), .failed_o(failed_o), .fatal_o(fatal_o)
  );

  // row: {tag, {err, core_req, chip, sys}, {sel, sw, crst[1:0], failed[1:0], fatal, chip, sys}}
  localparam logic [16:0] TBL [NROW] = '{
    {4'd1,  4'b0000, 9'b0_0_00_00_0_0_0},  // R1 idle after reset
    {4'd10, 4'b0010, 9'b0_0_00_00_0_1_0},  // R10 chip request edge
    {4'd10, 4'b0010, 9'b0_0_00_00_0_0_0},  // R10 held request, no repeat
    {4'd10, 4'b0001, 9'b0_0_00_00_0_0_1},  // R10 system request edge
    {4'd6,  4'b0100, 9'b0_1_01_00_0_0_0},  // R6 R4 core request: pulse core 0
    {4'd7,  4'b1000, 9'b0_1_00_00_0_0_0},  // R7 error ignored in switch
    {4'd7,  4'b1000, 9'b0_1_00_00_0_0_0},  // R7
    {4'd5,  4'b0000, 9'b0_1_00_00_0_0_0},  // R5 select held
    {4'd4,  4'b0000, 9'b1_0_00_00_0_0_0},  // R4 core 1 online, no flag
    {4'd2,  4'b0000, 9'b1_0_00_00_0_0_0},  // R2
    {4'd8,  4'b1000, 9'b1_1_10_10_0_0_0},  // R8 error marks core 1
    {4'd7,  4'b0100, 9'b1_1_00_10_0_0_0},  // R7 request ignored
    {4'd5,  4'b0000, 9'b1_1_00_10_0_0_0},  // R5
    {4'd2,  4'b0000, 9'b1_1_00_10_0_0_0},  // R2 last switch cycle
    {4'd3,  4'b0000, 9'b0_0_00_10_0_0_0},  // R3 back on core 0
    {4'd9,  4'b0100, 9'b0_0_00_10_0_0_0},  // R9 request blocked
    {4'd9,  4'b1000, 9'b0_0_00_11_1_0_0},  // R9 error -> fatal
    {4'd8,  4'b0000, 9'b0_0_00_11_1_0_0},  // R8 flags sticky
    {4'd10, 4'b1010, 9'b0_0_00_11_1_1_0},  // R10 chip pulse while fatal
    {4'd9,  4'b0100, 9'b0_0_00_11_1_0_0}   // R9 no switch
  };

  function automatic logic [8:0] outs();
    return {sel_o, switching_o, core_rst_o, failed_o, fatal_o, chip_rst_o, sys_rst_o};
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] v);
    {err_i, core_rst_req_i, chip_rst_req_i, sys_rst_req_i} = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1", outs(), 9'b0);
    rst_ni = 1'b1;
    for (int i = 0; i < NROW; i++) begin
      drive(TBL[i][12:9]);
      @(negedge clk);
      check($sformatf("R%0d row %0d", TBL[i][16:13], i), outs(), TBL[i][8:0]);
    end
    drive(4'b0000);

    // R1 asynchronous reset clears flags and fatal
    rst_ni = 1'b0;
    #1;
    check("R1 async clear", outs(), 9'b0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R2 switch length counted at ports
    drive(4'b1000);
    @(negedge clk);
    drive(4'b0000);
    n = 0;
    while (switching_o && n < 20) begin
      n++;
      @(negedge clk);
    end
    check("R2 switch cycles", 9'(n), 9'd4);
    check("R2 R8 after error", outs(), 9'b1_0_00_01_0_0_0);

    // R9 request blocked on core 1 with core 0 failed
    drive(4'b0100);
    @(negedge clk);
    drive(4'b0000);
    check("R9 blocked request", outs(), 9'b1_0_00_01_0_0_0);

    // R1 reset during a switch
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    drive(4'b0100);
    @(negedge clk);
    drive(4'b0000);
    check("R6 pulse on core 0", outs(), 9'b0_1_01_00_0_0_0);
    #2 rst_ni = 1'b0;
    #1 check("R1 reset mid-switch", outs(), 9'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 idle after release", outs(), 9'b0);
    finish_run();
  end
endmodule